// File: doc/BRIEF.md
# Programmable Raster Timing Generator

This block produces the horizontal and vertical timing of a progressive video raster from a bank of sixteen 32-bit timing registers. Software writes the registers over a simple 32-bit write bus, one register per 16-byte slot. The bus delivers data with its bytes in reverse order, and the block swaps them back before storing. The horizontal positions count character clocks. A character clock lasts a fixed number of pixel clocks, and that number is set by an external divider code. The vertical positions count half-lines.

The block does not hold active size or blanking lengths directly. It derives them from edge positions: where the active region starts, where it ends, and where the line or frame wraps. Besides the sync and active-video strobes and the pixel coordinates, it reports the active and total geometry in pixels and lines. Written values first go into a shadow copy. The whole set, together with the divider code, moves into the working copy only when a frame wraps, so a frame is never drawn with a mix of old and new settings.

Top module: `raster_timer`

## Requirements
- R1: The register slot is byte address bits [11:4]. Slot s, for s from 1 to 16, writes bank index s-1. Address bits [3:0] are ignored, and slot 0 and slots above 16 change nothing. The indices used are: 1 active-end half-line, 2 active-start half-line, 5 frame length in half-lines, 6 vsync width in half-lines, 9 active-end clock, 10 active-start clock, 12 line length in clocks, 13 hsync width in clocks.
- R2: The stored value is the low 12 bits of the write data after its four bytes are reversed, so bus byte [7:0] becomes stored bits [31:24].
- R3: Bank writes and the divider code reach the counters and the geometry outputs only in the cycle after the last pixel clock of a frame.
- R4: The divisor is 2^(code+1), giving 2, 4, 8 or 16 pixel clocks per character clock. The horizontal count runs from 0 to line length − 1. One line lasts line length × divisor pixel clocks.
- R5: The vertical count advances by 2 half-lines at each line end and returns to 0 when the next value would reach the frame length. A frame lasts frame length / 2 lines.
- R6: `active` is high when active-start clock ≤ h < active-end clock and active-start half-line ≤ v < active-end half-line. Every output is registered, one cycle after the counter state it reflects.
- R7: While active, `px_x` = (h − active-start clock) × divisor + pixel phase and `px_y` = (v − active-start half-line) / 2. Outside the active region both are 0.
- R8: `hsync` is high while h < hsync width. `vsync` is high while v < vsync width.
- R9: `act_w` = (active-end − active-start clock) × divisor and `act_h` = (active-end − active-start half-line) / 2. The totals add the blanking terms (start + length − end) × divisor and (start + length − end) / 2.
- R10: Synchronous active-high reset clears the counters, both register copies and all outputs, and sets the divider code to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 12 | Byte address of the write |
| reg_wdata | input | 32 | Byte-reversed write data |
| div_sel | input | 2 | Divider code, sampled at frame wrap |
| hsync | output | 1 | Horizontal sync |
| vsync | output | 1 | Vertical sync |
| active | output | 1 | Active-video strobe |
| px_x | output | 16 | Pixel column inside the active region |
| px_y | output | 12 | Line inside the active region |
| act_w | output | 16 | Active width in pixels |
| act_h | output | 12 | Active height in lines |
| tot_w | output | 16 | Total line length in pixels |
| tot_h | output | 12 | Total frame length in lines |

## Verification
The hardest situation to reach is a write that arrives while a frame is in progress and then has to stay invisible until the frame wraps. This is made worse because a write can land in the very cycle of the wrap, when the old shadow value must still be the one taken. The bench runs a cycle-accurate reference of the shadow and working copies. It changes the line length in the middle of a long frame, checks that the geometry holds until the wrap, and lets random configurations be written back to back while frames keep wrapping. Slot aliasing is tested with writes to slots whose index, cut to four bits, would land on a register that is in use.

// File: rtl/rtg_pkg.sv
package rtg_pkg;
  localparam int TW     = 12;          // counter and register width
  localparam int DW     = 2;           // divider code width
  localparam int SUBW   = 2 ** DW;     // pixel phase width (max divisor 16)
  localparam int GW     = TW + SUBW;   // pixel geometry width
  localparam int NREG   = 16;
  localparam int IDX_W  = $clog2(NREG);

  localparam int IX_V_END   = 1;
  localparam int IX_V_START = 2;
  localparam int IX_V_TOTAL = 5;
  localparam int IX_V_SW    = 6;
  localparam int IX_H_END   = 9;
  localparam int IX_H_START = 10;
  localparam int IX_H_TOTAL = 12;
  localparam int IX_H_SW    = 13;

  typedef struct packed {
    logic [TW-1:0] v_end;
    logic [TW-1:0] v_start;
    logic [TW-1:0] v_total;
    logic [TW-1:0] v_sw;
    logic [TW-1:0] h_end;
    logic [TW-1:0] h_start;
    logic [TW-1:0] h_total;
    logic [TW-1:0] h_sw;
    logic [DW-1:0] div_code;
  } tmg_cfg_t;

  function automatic logic [31:0] bswap32(input logic [31:0] d);
    return {d[7:0], d[15:8], d[23:16], d[31:24]};
  endfunction
endpackage

// File: rtl/rtg_regbank.sv
module rtg_regbank
  import rtg_pkg::*;
#(
  parameter int ADDR_W = 12
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  input  logic [31:0]       wdata,
  input  logic [DW-1:0]     div_sel,
  input  logic              frame_wrap,
  output tmg_cfg_t          live
);
  localparam int SLOT_W = ADDR_W - 4;

  logic [SLOT_W-1:0] slot;
  logic [31:0]       swapped;
  logic              hit;
  logic [IDX_W-1:0]  idx;
  logic [TW-1:0]     shadow [NREG];
  logic              unused_bits;

  assign slot        = addr[ADDR_W-1:4];
  assign swapped     = bswap32(wdata);
  assign hit         = we && (slot >= SLOT_W'(1)) && (slot <= SLOT_W'(NREG));
  assign idx         = IDX_W'(slot - SLOT_W'(1));
  assign unused_bits = ^{addr[3:0], swapped[31:TW]};

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NREG; i++) shadow[i] <= '0;
    end else if (hit) begin
      shadow[idx] <= swapped[TW-1:0];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      live <= '0;
    end else if (frame_wrap) begin
      live.v_end    <= shadow[IX_V_END];
      live.v_start  <= shadow[IX_V_START];
      live.v_total  <= shadow[IX_V_TOTAL];
      live.v_sw     <= shadow[IX_V_SW];
      live.h_end    <= shadow[IX_H_END];
      live.h_start  <= shadow[IX_H_START];
      live.h_total  <= shadow[IX_H_TOTAL];
      live.h_sw     <= shadow[IX_H_SW];
      live.div_code <= div_sel;
    end
  end
endmodule

// File: rtl/rtg_counters.sv
module rtg_counters
  import rtg_pkg::*;
(
  input  logic            clk,
  input  logic            rst,
  input  tmg_cfg_t        cfg,
  output logic [SUBW-1:0] sub,
  output logic [TW-1:0]   hcnt,
  output logic [TW-1:0]   vcnt,
  output logic            frame_wrap
);
  logic [SUBW:0] div;
  logic          sub_last;
  logic          h_last;
  logic          v_last;

  assign div        = (SUBW+1)'(2) << cfg.div_code;
  assign sub_last   = ({1'b0, sub} == div - (SUBW+1)'(1));
  assign h_last     = ({1'b0, hcnt} + (TW+1)'(1)) >= {1'b0, cfg.h_total};
  assign v_last     = ({1'b0, vcnt} + (TW+1)'(2)) >= {1'b0, cfg.v_total};
  assign frame_wrap = sub_last && h_last && v_last;

  always_ff @(posedge clk) begin
    if (rst) begin
      sub  <= '0;
      hcnt <= '0;
      vcnt <= '0;
    end else if (!sub_last) begin
      sub <= sub + SUBW'(1);
    end else begin
      sub <= '0;
      if (!h_last) begin
        hcnt <= hcnt + TW'(1);
      end else begin
        hcnt <= '0;
        vcnt <= v_last ? '0 : vcnt + TW'(2);
      end
    end
  end
endmodule

// File: rtl/rtg_outputs.sv
module rtg_outputs
  import rtg_pkg::*;
(
  input  logic            clk,
  input  logic            rst,
  input  tmg_cfg_t        cfg,
  input  logic [SUBW-1:0] sub,
  input  logic [TW-1:0]   hcnt,
  input  logic [TW-1:0]   vcnt,
  output logic            hsync,
  output logic            vsync,
  output logic            active,
  output logic [GW-1:0]   px_x,
  output logic [TW-1:0]   px_y,
  output logic [GW-1:0]   act_w,
  output logic [TW-1:0]   act_h,
  output logic [GW-1:0]   tot_w,
  output logic [TW-1:0]   tot_h
);
  int            sh;
  logic          in_h, in_v, act_n;
  logic [TW-1:0] h_off, v_off;
  logic [TW-1:0] h_len, h_blank, v_len, v_blank;
  logic [GW-1:0] w_act_n, w_blank_n;

  always_comb begin
    sh        = int'(cfg.div_code) + 1;
    in_h      = (hcnt >= cfg.h_start) && (hcnt < cfg.h_end);
    in_v      = (vcnt >= cfg.v_start) && (vcnt < cfg.v_end);
    act_n     = in_h && in_v;
    h_off     = hcnt - cfg.h_start;
    v_off     = vcnt - cfg.v_start;
    h_len     = cfg.h_end - cfg.h_start;
    h_blank   = cfg.h_start + cfg.h_total - cfg.h_end;
    v_len     = cfg.v_end - cfg.v_start;
    v_blank   = cfg.v_start + cfg.v_total - cfg.v_end;
    w_act_n   = GW'(h_len) << sh;
    w_blank_n = GW'(h_blank) << sh;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      hsync  <= 1'b0;
      vsync  <= 1'b0;
      active <= 1'b0;
      px_x   <= '0;
      px_y   <= '0;
      act_w  <= '0;
      act_h  <= '0;
      tot_w  <= '0;
      tot_h  <= '0;
    end else begin
      hsync  <= hcnt < cfg.h_sw;
      vsync  <= vcnt < cfg.v_sw;
      active <= act_n;
      px_x   <= act_n ? (GW'(h_off) << sh) + GW'(sub) : '0;
      px_y   <= act_n ? (v_off >> 1) : '0;
      act_w  <= w_act_n;
      act_h  <= v_len >> 1;
      tot_w  <= w_act_n + w_blank_n;
      tot_h  <= (v_len >> 1) + (v_blank >> 1);
    end
  end
endmodule

// File: rtl/raster_timer.sv
module raster_timer
  import rtg_pkg::*;
#(
  parameter int ADDR_W = 12
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_we,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [31:0]       reg_wdata,
  input  logic [DW-1:0]     div_sel,
  output logic              hsync,
  output logic              vsync,
  output logic              active,
  output logic [GW-1:0]     px_x,
  output logic [TW-1:0]     px_y,
  output logic [GW-1:0]     act_w,
  output logic [TW-1:0]     act_h,
  output logic [GW-1:0]     tot_w,
  output logic [TW-1:0]     tot_h
);
  tmg_cfg_t        cfg;
  logic [SUBW-1:0] sub;
  logic [TW-1:0]   hcnt;
  logic [TW-1:0]   vcnt;
  logic            frame_wrap;

  rtg_regbank #(.ADDR_W(ADDR_W)) u_bank (
    .clk(clk), .rst(rst), .we(reg_we), .addr(reg_addr), .wdata(reg_wdata),
    .div_sel(div_sel), .frame_wrap(frame_wrap), .live(cfg)
  );

  rtg_counters u_cnt (
    .clk(clk), .rst(rst), .cfg(cfg), .sub(sub), .hcnt(hcnt), .vcnt(vcnt),
    .frame_wrap(frame_wrap)
  );

  rtg_outputs u_out (
    .clk(clk), .rst(rst), .cfg(cfg), .sub(sub), .hcnt(hcnt), .vcnt(vcnt),
    .hsync(hsync), .vsync(vsync), .active(active), .px_x(px_x), .px_y(px_y),
    .act_w(act_w), .act_h(act_h), .tot_w(tot_w), .tot_h(tot_h)
  );
endmodule

// File: rtl/raster_timer_chk.sv
module raster_timer_chk
  import rtg_pkg::*;
(
  input logic          clk,
  input logic          rst,
  input logic          frame_wrap,
  input logic          hsync,
  input logic          vsync,
  input logic          active,
  input logic [GW-1:0] px_x,
  input logic [TW-1:0] px_y,
  input logic [GW-1:0] act_w
);
  assert_quiet_after_reset_R10: assert property (@(posedge clk)
    rst |=> (!active && !hsync && !vsync && px_x == '0 && px_y == '0));

  assert_coords_idle_R7: assert property (@(posedge clk) disable iff (rst)
    !active |-> (px_x == '0 && px_y == '0));

  assert_x_inside_width_R9: assert property (@(posedge clk) disable iff (rst)
    active |-> (px_x < act_w));

  assert_x_steps_R7: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && active && $past(active) && px_y == $past(px_y))
      |-> (px_x == $past(px_x) + GW'(1)));

  assert_geom_at_wrap_R3: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(rst, 2) && act_w != $past(act_w))
      |-> $past(frame_wrap, 2));
endmodule

bind raster_timer raster_timer_chk u_chk (
  .clk(clk), .rst(rst), .frame_wrap(frame_wrap), .hsync(hsync), .vsync(vsync),
  .active(active), .px_x(px_x), .px_y(px_y), .act_w(act_w)
);

// File: tb/raster_timer_test.sv
module raster_timer_test;
  localparam int CLK_PERIOD = 10;
  localparam int A_V_END = 'h20, A_V_START = 'h30, A_V_TOTAL = 'h60, A_V_SW = 'h70;
  localparam int A_H_END = 'hA0, A_H_START = 'hB0, A_H_TOTAL = 'hD0, A_H_SW = 'hE0;
  localparam int I_V_END = 1, I_V_START = 2, I_V_TOTAL = 5, I_V_SW = 6;
  localparam int I_H_END = 9, I_H_START = 10, I_H_TOTAL = 12, I_H_SW = 13;

  logic clk = 0, rst = 1, reg_we = 0;
  logic [11:0] reg_addr = 0;
  logic [31:0] reg_wdata = 0;
  logic [1:0] div_sel = 0;
  logic hsync, vsync, active;
  logic [15:0] px_x, act_w, tot_w;
  logic [11:0] px_y, act_h, tot_h;

  raster_timer uut (
    .clk(clk), .rst(rst), .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .div_sel(div_sel), .hsync(hsync), .vsync(vsync), .active(active), .px_x(px_x),
    .px_y(px_y), .act_w(act_w), .act_h(act_h), .tot_w(tot_w), .tot_h(tot_h)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int checks = 0, errors = 0;

  task automatic chk(input bit ok, input string tag, input int a, input int e);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, a, e);
    end
  endtask

  function automatic logic [31:0] rev_bytes(input logic [31:0] d);
    return {d[7:0], d[15:8], d[23:16], d[31:24]};
  endfunction

  // reference model
  int pend[16], live[16], l_div, m_sub, m_h, m_v, m_frames;
  bit armed = 0, e_hs, e_vs, e_act;
  int e_x, e_y, e_aw, e_ah, e_tw, e_th;
  bit e_geo_ok;

  always @(negedge clk) begin
    if (armed) begin
      chk(active === e_act, "R6 active", active, e_act);
      chk(hsync === e_hs && vsync === e_vs, "R8 sync", {hsync, vsync}, {e_hs, e_vs});
      chk(px_x === 16'(e_x) && px_y === 12'(e_y), "R7 coords", {px_x, px_y}, (e_x << 12) | e_y);
      if (e_geo_ok) begin
        chk(act_w === 16'(e_aw) && act_h === 12'(e_ah), "R9 active size",
            {act_w, act_h}, (e_aw << 12) | e_ah);
        chk(tot_w === 16'(e_tw) && tot_h === 12'(e_th), "R9 total size",
            {tot_w, tot_h}, (e_tw << 12) | e_th);
      end
    end
    if (rst) begin
      foreach (pend[i]) begin pend[i] = 0; live[i] = 0; end
      l_div = 0; m_sub = 0; m_h = 0; m_v = 0;
      e_hs = 0; e_vs = 0; e_act = 0; e_x = 0; e_y = 0;
      e_aw = 0; e_ah = 0; e_tw = 0; e_th = 0; e_geo_ok = 1; armed = 1;
    end else begin
      int dv, hs, he, ht, vs, ve, vt;
      bit wrap;
      dv = 2 << l_div;
      hs = live[I_H_START]; he = live[I_H_END]; ht = live[I_H_TOTAL];
      vs = live[I_V_START]; ve = live[I_V_END]; vt = live[I_V_TOTAL];
      e_act = m_h >= hs && m_h < he && m_v >= vs && m_v < ve;
      e_x = e_act ? (m_h - hs) * dv + m_sub : 0;
      e_y = e_act ? (m_v - vs) / 2 : 0;
      e_hs = m_h < live[I_H_SW];
      e_vs = m_v < live[I_V_SW];
      e_geo_ok = hs <= he && he <= ht && vs <= ve && ve <= vt &&
                 vs % 2 == 0 && ve % 2 == 0 && vt % 2 == 0;
      e_aw = (he - hs) * dv; e_ah = (ve - vs) / 2; e_tw = ht * dv; e_th = vt / 2;
      wrap = 0;
      if (m_sub == dv - 1) begin
        m_sub = 0;
        if (m_h + 1 >= ht) begin
          m_h = 0;
          if (m_v + 2 >= vt) begin m_v = 0; wrap = 1; end
          else m_v += 2;
        end else m_h++;
      end else m_sub++;
      if (wrap) begin
        foreach (live[i]) live[i] = pend[i];
        l_div = div_sel; m_frames++;
      end
      if (reg_we && reg_addr[11:4] >= 1 && reg_addr[11:4] <= 16)
        pend[reg_addr[11:4] - 1] = rev_bytes(reg_wdata) & 32'hFFF;
    end
  end

  task automatic wr(input int addr, input int val);
    @(posedge clk); #1;
    reg_we = 1; reg_addr = 12'(addr); reg_wdata = rev_bytes(32'(val));
    @(posedge clk); #1;
    reg_we = 0;
  endtask

  task automatic wait_frames(input int n);
    int target = m_frames + n;
    while (m_frames < target) @(negedge clk);
  endtask

  task automatic config_all(input int hs, he, ht, hw, vs, ve, vt, vw, dc);
    wr(A_H_START, hs); wr(A_H_END, he); wr(A_H_TOTAL, ht); wr(A_H_SW, hw);
    wr(A_V_START, vs); wr(A_V_END, ve); wr(A_V_TOTAL, vt); wr(A_V_SW, vw);
    div_sel = 2'(dc);
    wait_frames(2);
  endtask

  task automatic rise_period(input bit use_v, output int n);
    bit prev = 1, cur;
    forever begin
      @(negedge clk); cur = use_v ? vsync : hsync;
      if (cur && !prev) break;
      prev = cur;
    end
    prev = cur; n = 0;
    forever begin
      @(negedge clk); n++; cur = use_v ? vsync : hsync;
      if (cur && !prev) break;
      prev = cur;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 190000);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int n, w0, h0;
    void'($urandom(32'd20240611));
    repeat (4) @(posedge clk);
    #1 rst = 0;
    @(negedge clk);
    // R10: reset state
    chk(!active && !hsync && !vsync && px_x == 0 && act_w == 0 && tot_h == 0,
        "R10 reset state", {active, hsync, vsync}, 0);

    // R2 / R4 / R5: directed configuration, divisor code 1 (4 clocks)
    config_all(3, 13, 16, 2, 4, 14, 18, 2, 1);
    chk(act_w == 40 && act_h == 5, "R2 byte-reversed storage", act_w, 40);
    rise_period(0, n);
    chk(n == 16 * 4, "R4 line period", n, 64);
    rise_period(1, n);
    chk(n == 16 * 4 * 9, "R5 frame period", n, 576);

    // R1: ignored slots, including ones that alias used indices when cut to 4 bits
    w0 = act_w; h0 = act_h;
    wr('h000, 7); wr('h120, 1); wr('h1A0, 2); wr('hFF0, 5);
    wait_frames(2);
    chk(act_w == w0 && act_h == h0, "R1 out-of-range slot ignored", act_w, w0);
    wr('hA7, 11);   // low address bits ignored: lands on active-end clock
    wait_frames(2);
    chk(act_w == (11 - 3) * 4, "R1 low address bits ignored", act_w, 32);

    // R3: mid-frame change held until the wrap
    config_all(2, 10, 12, 1, 2, 10, 14, 2, 3);
    wait_frames(1);
    repeat (50) @(negedge clk);
    wr(A_H_TOTAL, 14);
    div_sel = 2;
    repeat (20) @(negedge clk);
    chk(tot_w == 12 * 16, "R3 held during frame", tot_w, 192);
    wait_frames(1);
    repeat (3) @(negedge clk);
    chk(tot_w == 14 * 8, "R3 applied after wrap", tot_w, 112);

    // edge cases: active from clock 0 to line end, no vsync gap at top
    config_all(0, 10, 10, 3, 0, 8, 12, 1, 0);
    rise_period(0, n);
    chk(n == 20, "R4 divisor code 0", n, 20);

    // random configurations
    for (int k = 0; k < 10; k++) begin
      int ht, hs, he, hw, vt, vs, ve, vw, dc;
      ht = 4 + $urandom_range(0, 12);
      hs = $urandom_range(0, ht - 2);
      he = hs + 1 + $urandom_range(0, ht - hs - 1);
      hw = 1 + $urandom_range(0, ht - 2);
      vt = 2 * (2 + $urandom_range(0, 6));
      vs = 2 * $urandom_range(0, vt / 2 - 2);
      ve = vs + 2 * (1 + $urandom_range(0, (vt - vs) / 2 - 2));
      vw = 1 + $urandom_range(0, vt - 2);
      dc = $urandom_range(0, 3);
      config_all(hs, he, ht, hw, vs, ve, vt, vw, dc);
      rise_period(0, n);
      chk(n == ht * (2 << dc), "R4 random line period", n, ht * (2 << dc));
    end

    wait_frames(1);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule